// File: doc/BRIEF.md
# Slew-Rate Input Debouncer

This block cleans up one asynchronous digital input. The input passes through a two-stage synchronizer, and the synchronized level then drives an integrating up/down counter. The counter only changes on a slow time base, one step every `TICK_DIV` clocks; the default of 500 gives 10 µs at a 50 MHz clock. On each step the counter grows by the rise rate while the input is high and shrinks by the fall rate while it is low. It saturates at zero and at full scale. The clean output comes from a hysteresis comparator on the counter.

Host software programs slew rates, not delays. A rate is proportional to the reciprocal of the wanted delay, and the host does the division. When rise and fall rates are equal, the block acts as a symmetric band-limiting filter. When they differ, it acts as a glitch catcher: a short pulse can set the output, and the output then stays set long enough for slow software to notice it much later. A glitch against the present level does not restart anything. It only pulls the count back by its own width, so the approach to the threshold is delayed by that amount.

Top module: `slew_debounce`

## Requirements
- R1: After reset the output `dout` is 0 and the integrator holds zero.
- R2: `din_raw` is used only after two flip-flop stages. A level change made two clocks before a time-base step is not seen by that step but is seen by the next one.
- R3: The integrator changes only on a time-base step, which occurs once every `TICK_DIV` clocks counted from reset release. On a step with the synchronized input high, it adds `rise_rate`.
- R4: On a step with the synchronized input low, the integrator subtracts `fall_rate`.
- R5: The integrator saturates at 0 and at full scale (2^18-1 with the default width). It never wraps.
- R6: The output goes to 1 in the same cycle that the integrator reaches or passes the upper threshold, 3/4 of full scale (196608 for 18 bits).
- R7: The output goes to 0 in the same cycle that the integrator reaches or falls below the lower threshold, 1/4 of full scale (65536 for 18 bits).
- R8: While the integrator lies strictly between the two thresholds, the output keeps its previous value.
- R9: A glitch against the present level reduces the count by that glitch's own contribution and does not reset it. The remaining progress toward the threshold is kept.
- R10: A rate of 0 freezes the integrator in that direction.
- R11: With a fall rate smaller than the rise rate, a pulse a few steps long holds the output high for many more steps. The hold time is (count − lower threshold) / fall_rate steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_raw | input | 1 | Asynchronous raw input |
| rise_rate | input | ACC_W | Amount added per step while input is high |
| fall_rate | input | ACC_W | Amount subtracted per step while input is low |
| dout | output | 1 | Debounced output |

## Verification
The integrator value cannot be seen at the ports, so the hardest cases to reach are the exact thresholds and the two saturation limits. The stimulus reaches them through the output alone. It picks rate values that land the count exactly on 196608, 65538 and 65536, and it overdrives past both limits. It then chooses the number of steps back to a threshold so that a wrapped count would give a different output. The synchronizer depth is checked by changing the input exactly two clocks before a step, which is possible because the stimulus stays aligned to the time base from reset release.

// File: rtl/slew_debounce.sv
module slew_debounce #(
  parameter int TICK_DIV = 500,
  parameter int ACC_W    = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_raw,
  input  logic [ACC_W-1:0] rise_rate,
  input  logic [ACC_W-1:0] fall_rate,
  output logic             dout
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);
  localparam logic [ACC_W-1:0] FULL  = '1;
  localparam logic [ACC_W-1:0] HI_TH = {2'b11, {(ACC_W-2){1'b0}}};
  localparam logic [ACC_W-1:0] LO_TH = {2'b01, {(ACC_W-2){1'b0}}};

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] acc_q, acc_n;
  logic [ACC_W:0]   up_sum, dn_dif;
  logic             tick, lvl, dout_n;

  assign lvl    = sync_q[1];
  assign tick   = (cnt_q == CNT_LAST);
  assign up_sum = {1'b0, acc_q} + {1'b0, rise_rate};
  assign dn_dif = {1'b0, acc_q} - {1'b0, fall_rate};

  always_comb begin
    acc_n = acc_q;
    if (tick) begin
      if (lvl) acc_n = up_sum[ACC_W] ? FULL : up_sum[ACC_W-1:0];
      else     acc_n = dn_dif[ACC_W] ? '0   : dn_dif[ACC_W-1:0];
    end
  end

  assign dout_n = (acc_n >= HI_TH) ? 1'b1 : (acc_n <= LO_TH) ? 1'b0 : dout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
      dout   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], din_raw};
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      acc_q  <= acc_n;
      dout   <= dout_n;
    end
  end

  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(acc_q));
  a_r5_up_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lvl) |=> acc_q >= $past(acc_q));
  a_r5_dn_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !lvl) |=> acc_q <= $past(acc_q));
  a_r6_high_above: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q >= HI_TH) |-> dout);
  a_r7_low_below: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= LO_TH) |-> !dout);
  a_r8_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q > LO_TH && acc_q < HI_TH && $past(rst_n)) |-> dout == $past(dout));
  a_r10_rise_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lvl && rise_rate == '0) |=> $stable(acc_q));
endmodule

// File: tb/slew_debounce_tb_top.sv
module slew_debounce_tb_top;
  localparam int TD = 4;
  localparam int W  = 18;
  localparam int FULL = (1 << W) - 1;
  localparam int HI = 3 << (W-2);
  localparam int LO = 1 << (W-2);

  logic clk = 0, rst_n = 0, din_raw = 0, dout;
  logic [W-1:0] rise_rate = '0, fall_rate = '0;
  int total = 0, bad = 0;
  int m_acc = 0;
  bit m_out = 0;
  bit done = 0;
  bit    q_exp[$];
  string q_tag[$];
  event chk_ev;

  always #10 clk = ~clk;

  slew_debounce #(.TICK_DIV(TD), .ACC_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .din_raw(din_raw),
    .rise_rate(rise_rate), .fall_rate(fall_rate), .dout(dout));

  task automatic model_step(input bit lv);
    if (lv) m_acc = (m_acc + rise_rate > FULL) ? FULL : m_acc + rise_rate;
    else    m_acc = (m_acc < fall_rate) ? 0 : m_acc - fall_rate;
    if (m_acc >= HI) m_out = 1;
    else if (m_acc <= LO) m_out = 0;
  endtask

  task automatic push(input bit e, input string tag);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    -> chk_ev;
  endtask

  task automatic seg(input bit lv, input int k, input string tag);
    din_raw = lv;
    for (int i = 0; i < k; i++) begin
      repeat (TD) @(posedge clk);
      model_step(lv);
    end
    @(negedge clk);
    push(m_out, tag);
  endtask

  always begin
    @(chk_ev);
    while (q_exp.size() > 0) begin
      bit e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      total++;
      if (dout !== e) begin
        bad++;
        $display("FAIL %s: dout=%b expected=%b", t, dout, e);
      end
    end
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    push(1'b0, "R1");
    // R2: raise input two clocks before a step; that step must not see it
    rise_rate = W'(196608); fall_rate = '0;
    repeat (TD-2) @(posedge clk);
    @(negedge clk); din_raw = 1;
    repeat (2) @(posedge clk);
    model_step(1'b0);
    @(negedge clk); push(m_out, "R2");
    seg(1, 1, "R2");
    fall_rate = W'(196608);
    seg(0, 1, "R4");
    // R3 / R6: step cadence and exact upper threshold
    rise_rate = W'(65536);
    seg(1, 2, "R3");
    din_raw = 1;
    repeat (TD-1) @(posedge clk);
    @(negedge clk); push(m_out, "R3");
    @(posedge clk); model_step(1'b1);
    @(negedge clk); push(m_out, "R6");
    // R5 top saturation, R8 band hold, R7 exact lower threshold
    seg(1, 10, "R5");
    fall_rate = W'(65535);
    seg(0, 1, "R8");
    seg(0, 2, "R8");
    fall_rate = W'(2);
    seg(0, 1, "R7");
    // R5 bottom saturation then climb
    fall_rate = W'(65536);
    seg(0, 3, "R5");
    seg(1, 2, "R5");
    seg(1, 1, "R5");
    // R10: zero rates freeze
    rise_rate = '0; fall_rate = '0;
    seg(0, 5, "R10");
    seg(1, 5, "R10");
    fall_rate = W'(65536);
    seg(0, 1, "R10");
    seg(0, 1, "R10");
    // R9: glitch only subtracts its own share
    rise_rate = W'(65536);
    seg(0, 1, "R9");
    seg(1, 2, "R9");
    seg(0, 1, "R9");
    seg(1, 1, "R9");
    seg(1, 1, "R9");
    // R11: asymmetric hold
    fall_rate = W'(8192);
    seg(0, 15, "R11");
    seg(0, 1, "R11");
    #1;
    if (q_exp.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: pending=%0d expected=0", q_exp.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule